// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Core

This block is a synthesizable behavioural model of a pipelined synchronous burst memory built from four byte lanes. Each lane carries eight data bits and one parity bit, so one word is 36 bits wide. Two active-low address strobes can open a burst: one serves a processor and one serves a cache controller. Each strobe loads an external address. A two-bit beat counter then walks a four-word group in linear or interleaved order, stepping only while the advance input is low. Three chip selects gate every start, and the processor strobe also depends on the primary select.

Writes come in two kinds. The global write enable writes the whole word. The byte-write enable hands control to one enable per lane. Read data is held in a register and reaches the output in the cycle after the clock edge that performs the access. The output-enable input and the sleep input gate the output at once, without waiting for a clock edge. While sleep is high, the stored words and the burst state stay frozen. After sleep falls, the block keeps ignoring both strobes for two more clock edges and flags any strobe that arrives in that window.

Top module: `burst_sram_core`

## Requirements
- R1: While reset is held and just after it is released, `dq_oe` is 0, `rdata` is all zero, `wake_err` is 0 and no burst is open.
- R2: At an edge where `strb_proc_n` is low and all three selects are active (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0), a burst opens at `addr` and that word is always read, whatever the write inputs are. The processor strobe wins when both strobes are low. The word appears on `rdata`, with `dq_oe`=1 if `oe_n`=0, in the cycle after that edge.
- R3: When `sel_a_n` is high, `strb_proc_n` has no effect. If `strb_ctl_n` is also high, the edge behaves as if no strobe were present, and an open burst keeps its starting address.
- R4: If an accepted strobe sees any chip select inactive, the burst closes. The output is undriven from then until the next started burst.
- R5: At an edge where `strb_ctl_n` is low and the processor strobe is not taken, a burst opens at `addr`. The write inputs decide whether that edge is a read or a write. After a write edge, `dq_oe` is 0.
- R6: `gwr_n`=0 writes all lanes of the addressed word, whatever `bwr_n` and `lane_wr_n` are.
- R7: With `gwr_n`=1 and `bwr_n`=0, each lane i whose `lane_wr_n[i]` is 0 takes bits [9i+8:9i] of `wdata`. The other lanes keep their old contents.
- R8: An edge is a read when `gwr_n` and `bwr_n` are both 1, or when `bwr_n`=0 and all `lane_wr_n` bits are 1. A single edge never both reads and writes.
- R9: With an open burst and no strobe taken, `adv_n`=0 moves to the next beat and accesses it. The low two address bits are (start + beat) mod 4 when `seq_ilv`=0, and start XOR beat when `seq_ilv`=1. After the fourth beat the sequence wraps, and the upper address bits do not change.
- R10: With an open burst, no strobe taken and `adv_n`=1, the same address is accessed again. This holds for both reads and writes.
- R11: `oe_n`=1 forces `dq_oe` to 0 and `rdata` to 0 immediately, without waiting for a clock edge.
- R12: While `sleep`=1 the output is undriven at once and no edge changes the stored words or the burst state. Both strobes are ignored at the first two edges after `sleep` falls, and normal operation resumes at the third edge.
- R13: A strobe that is low at one of those two wake-up edges is ignored, and `wake_err` is 1 for the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| addr | input | ADDR_W | External word address, loaded when a burst starts |
| strb_proc_n | input | 1 | Processor burst-start strobe, active low, read only |
| strb_ctl_n | input | 1 | Controller burst-start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Primary chip select, active low; also gates the processor strobe |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| gwr_n | input | 1 | Global write enable for the whole word, active low |
| bwr_n | input | 1 | Byte-write enable; passes control to the lane enables, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low, lane 0 = lowest bits |
| seq_ilv | input | 1 | Beat order: 1 = interleaved, 0 = linear |
| sleep | input | 1 | Power-down request, active high |
| oe_n | input | 1 | Output enable, active low, takes effect without a clock edge |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data; zero while not driven |
| dq_oe | output | 1 | High while `rdata` is driven |
| wake_err | output | 1 | Strobe seen during the wake-up window |

## Verification
On every cycle, the assertions check how the burst counter behaves. They check that a blocked processor strobe leaves the starting address alone, that a failed select closes the burst, that suspend holds the beat and advance steps it by one, and that no write reaches the lanes while the block is asleep or waking. They also check that a wake-up error has a cause in the edge before it and that the counter starts from two when sleep falls. Only the bench scenarios can show that data survives the whole path. That covers word and lane-masked writes followed by reads in both beat orders, the wrap after four beats, words kept unchanged across a sleep period, and the output enable taking effect within a clock cycle.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  localparam int OFS_W = 2;

  // Low address bits of a beat inside a four-word group.
  function automatic logic [OFS_W-1:0] burst_offset(
    input logic [OFS_W-1:0] start_ofs,
    input logic [OFS_W-1:0] beat,
    input logic             ilv
  );
    logic [OFS_W-1:0] r;
    if (ilv) r = start_ofs ^ beat;
    else     r = start_ofs + beat;
    return r;
  endfunction

endpackage

// File: rtl/sram_wake_gate.sv
module sram_wake_gate #(
  parameter int WAKE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  input  logic strobe_seen,
  output logic frozen,
  output logic wake_err
);
  localparam int CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0] wake_cnt;
  logic          in_window;

  assign in_window = (wake_cnt != '0);
  assign frozen    = sleep || in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_cnt <= '0;
      wake_err <= 1'b0;
    end else begin
      wake_err <= !sleep && in_window && strobe_seen;
      if (sleep)          wake_cnt <= CW'(WAKE_CYC);
      else if (in_window) wake_cnt <= wake_cnt - 1'b1;
    end
  end

  // R12: the window is full length on the first edge after sleep falls
  p_wake_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep) |-> (wake_cnt == CW'(WAKE_CYC)));

  // R13: an error flag always has a strobe in the window one edge before
  p_err_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
    wake_err |-> $past(strobe_seen && !sleep));

endmodule

// File: rtl/sram_burst_ctl.sv
module sram_burst_ctl
  import sram_burst_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frozen,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strb_proc_n,
  input  logic              strb_ctl_n,
  input  logic              adv_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              seq_ilv,
  input  logic [LANES-1:0]  wr_mask,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  acc_wr,
  output logic              acc_rd,
  output logic              burst_act
);
  logic              burst_act_q;
  logic [ADDR_W-1:0] base_q;
  logic [OFS_W-1:0]  step_q;
  logic [OFS_W-1:0]  step_nxt;
  logic              proc_take;
  logic              ctl_take;
  logic              load;
  logic              chips_ok;
  logic              start;
  logic              cont;
  logic              may_write;

  always_comb begin
    proc_take = !strb_proc_n && !sel_a_n;
    ctl_take  = !strb_ctl_n && !proc_take;
    chips_ok  = !sel_a_n && sel_b && !sel_c_n;
    load      = !frozen && (proc_take || ctl_take);
    start     = load && chips_ok;
    cont      = !frozen && !load && burst_act_q;
    step_nxt  = adv_n ? step_q : step_q + 1'b1;
    if (start)
      acc_addr = addr;
    else
      acc_addr = {base_q[ADDR_W-1:OFS_W],
                  burst_offset(base_q[OFS_W-1:0], step_nxt, seq_ilv)};
    may_write = (start && ctl_take) || cont;
    acc_wr    = may_write ? wr_mask : '0;
    acc_rd    = (start || cont) && (acc_wr == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_act_q <= 1'b0;
      base_q      <= '0;
      step_q      <= '0;
    end else if (load) begin
      burst_act_q <= chips_ok;
      if (chips_ok) begin
        base_q <= addr;
        step_q <= '0;
      end
    end else if (cont) begin
      step_q <= step_nxt;
    end
  end

  assign burst_act = burst_act_q;

  // R3: a processor strobe blocked by the primary select loads nothing
  p_blocked_proc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && !strb_proc_n && sel_a_n && strb_ctl_n) |=> $stable(base_q));

  // R4: an accepted strobe with a select inactive closes the burst
  p_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !chips_ok) |=> !burst_act_q);

  // R10: suspend keeps the beat
  p_suspend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && adv_n) |=> $stable(step_q));

  // R9: advance moves exactly one beat
  p_advance_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && !adv_n) |=> (step_q == $past(step_q) + 2'd1));

endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [LANES-1:0]         acc_wr,
  input  logic                     acc_rd,
  input  logic [LANES*LANE_W-1:0]  wdata,
  output logic [LANES*LANE_W-1:0]  q_word
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] q_lane;

    always_ff @(posedge clk) begin
      if (acc_wr[g]) cells[acc_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_lane <= '0;
      else if (acc_rd) q_lane <= cells[acc_addr];
    end

    assign q_word[g*LANE_W +: LANE_W] = q_lane;
  end

  // R8: one edge is a read or a write, never both
  p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_rd && (acc_wr != '0)));

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core #(
  parameter int ADDR_W   = 6,
  parameter int LANE_W   = 9,
  parameter int LANES    = 4,
  parameter int WAKE_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    strb_proc_n,
  input  logic                    strb_ctl_n,
  input  logic                    adv_n,
  input  logic                    sel_a_n,
  input  logic                    sel_b,
  input  logic                    sel_c_n,
  input  logic                    gwr_n,
  input  logic                    bwr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic                    seq_ilv,
  input  logic                    sleep,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    dq_oe,
  output logic                    wake_err
);
  localparam int WORD_W = LANES * LANE_W;

  // Lanes to write this edge: global write wins, else the lane enables.
  function automatic logic [LANES-1:0] lane_mask(
    input logic gw_n, input logic bw_n, input logic [LANES-1:0] lw_n);
    logic [LANES-1:0] m;
    if (!gw_n)      m = '1;
    else if (!bw_n) m = ~lw_n;
    else            m = '0;
    return m;
  endfunction

  logic              frozen;
  logic              strobe_seen;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  acc_wr;
  logic              acc_rd;
  logic              burst_act;
  logic [WORD_W-1:0] q_word;
  logic              q_valid;

  assign strobe_seen = !strb_proc_n || !strb_ctl_n;

  sram_wake_gate #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .strobe_seen(strobe_seen),
    .frozen     (frozen),
    .wake_err   (wake_err)
  );

  sram_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .frozen     (frozen),
    .addr       (addr),
    .strb_proc_n(strb_proc_n),
    .strb_ctl_n (strb_ctl_n),
    .adv_n      (adv_n),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .seq_ilv    (seq_ilv),
    .wr_mask    (lane_mask(gwr_n, bwr_n, lane_wr_n)),
    .acc_addr   (acc_addr),
    .acc_wr     (acc_wr),
    .acc_rd     (acc_rd),
    .burst_act  (burst_act)
  );

  sram_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_addr(acc_addr),
    .acc_wr  (acc_wr),
    .acc_rd  (acc_rd),
    .wdata   (wdata),
    .q_word  (q_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_valid <= 1'b0;
    else if (!frozen) q_valid <= acc_rd;
  end

  assign dq_oe = q_valid && !oe_n && !frozen;
  assign rdata = dq_oe ? q_word : '0;

  // R12: nothing is written while asleep or waking
  p_frozen_nowrite_r12: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |-> (acc_wr == '0));

  // R5: the cycle after a write edge drives no data
  p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr != '0) |=> !dq_oe);

  // R4: with no burst open and nothing read, the output stays undriven
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_act && !acc_rd && !frozen) |=> !dq_oe);

endmodule

// File: tb/burst_sram_core_bench.sv
module burst_sram_core_bench;
  localparam int AW = 6;
  localparam int LW = 9;
  localparam int NL = 4;
  localparam int WW = NL * LW;
  localparam int NV = 26;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          strb_proc_n = 1'b1, strb_ctl_n = 1'b1, adv_n = 1'b1;
  logic          sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0;
  logic          gwr_n = 1'b1, bwr_n = 1'b1;
  logic [NL-1:0] lane_wr_n = '1;
  logic          seq_ilv = 1'b0, sleep = 1'b0, oe_n = 1'b0;
  logic [WW-1:0] wdata = '0;
  logic [WW-1:0] rdata;
  logic          dq_oe, wake_err;

  burst_sram_core u_burst_sram_core (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strb_proc_n(strb_proc_n),
    .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
    .sel_c_n(sel_c_n), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_wr_n(lane_wr_n),
    .seq_ilv(seq_ilv), .sleep(sleep), .oe_n(oe_n), .wdata(wdata),
    .rdata(rdata), .dq_oe(dq_oe), .wake_err(wake_err));

  int checks = 0;
  int errors = 0;
  int n_step = 0;

  // reference state
  logic [WW-1:0] ref_mem [1<<AW];
  logic          m_act = 1'b0, m_qv = 1'b0, m_err = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_step = '0;
  logic [WW-1:0] m_q = '0;
  int            m_wake = 0;

  // vector: tag[22:19] sp sc adv | a_n b c_n | gw bw | lane[3:0] | ilv | addr
  localparam logic [22:0] VEC [NV] = '{
    {4'd6,  3'b101, 3'b010, 2'b01, 4'hF,    1'b0, 6'd8},  // R6 ctl write word @8
    {4'd6,  3'b110, 3'b010, 2'b01, 4'hF,    1'b0, 6'd0},  // R6 beat @9
    {4'd6,  3'b110, 3'b010, 2'b01, 4'hF,    1'b0, 6'd0},  // R6 beat @10
    {4'd6,  3'b110, 3'b010, 2'b01, 4'hF,    1'b0, 6'd0},  // R6 beat @11
    {4'd9,  3'b110, 3'b010, 2'b01, 4'hF,    1'b0, 6'd0},  // R9 wrap to @8
    {4'd7,  3'b101, 3'b010, 2'b10, 4'b1010, 1'b0, 6'd9},  // R7 lanes 0,2 @9
    {4'd10, 3'b111, 3'b010, 2'b10, 4'b0111, 1'b0, 6'd0},  // R10 suspend, lane 3 @9
    {4'd2,  3'b011, 3'b010, 2'b01, 4'hF,    1'b0, 6'd9},  // R2 read despite gw low
    {4'd9,  3'b110, 3'b010, 2'b11, 4'hF,    1'b0, 6'd0},  // R9 @10
    {4'd10, 3'b111, 3'b010, 2'b11, 4'hF,    1'b0, 6'd0},  // R10 @10 again
    {4'd9,  3'b110, 3'b010, 2'b11, 4'hF,    1'b0, 6'd0},  // R9 @11
    {4'd9,  3'b110, 3'b010, 2'b11, 4'hF,    1'b0, 6'd0},  // R9 @8
    {4'd9,  3'b110, 3'b010, 2'b11, 4'hF,    1'b0, 6'd0},  // R9 @9 wrap
    {4'd2,  3'b011, 3'b010, 2'b11, 4'hF,    1'b1, 6'd10}, // R2 interleaved start @10
    {4'd9,  3'b110, 3'b010, 2'b11, 4'hF,    1'b1, 6'd0},  // R9 @11
    {4'd9,  3'b110, 3'b010, 2'b11, 4'hF,    1'b1, 6'd0},  // R9 @8
    {4'd9,  3'b110, 3'b010, 2'b11, 4'hF,    1'b1, 6'd0},  // R9 @9
    {4'd3,  3'b010, 3'b110, 2'b11, 4'hF,    1'b1, 6'd20}, // R3 blocked, continue @10
    {4'd4,  3'b101, 3'b000, 2'b11, 4'hF,    1'b0, 6'd8},  // R4 sel_b low
    {4'd4,  3'b110, 3'b010, 2'b11, 4'hF,    1'b0, 6'd0},  // R4 stays closed
    {4'd8,  3'b101, 3'b010, 2'b10, 4'hF,    1'b0, 6'd11}, // R8 bw low, no lane
    {4'd4,  3'b011, 3'b011, 2'b11, 4'hF,    1'b0, 6'd9},  // R4 sel_c_n high
    {4'd7,  3'b101, 3'b010, 2'b10, 4'b1101, 1'b0, 6'd11}, // R7 lane 1 @11
    {4'd5,  3'b101, 3'b010, 2'b11, 4'hF,    1'b0, 6'd11}, // R5 ctl read @11
    {4'd3,  3'b001, 3'b110, 2'b11, 4'hF,    1'b0, 6'd9},  // R3 proc blocked, ctl deselects
    {4'd2,  3'b001, 3'b010, 2'b01, 4'hF,    1'b0, 6'd8}   // R2 proc wins over ctl
  };

  task automatic chk(input int rq, input logic [WW-1:0] got, input logic [WW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d got %h expected %h", rq, got, exp);
    end
  endtask

  function automatic logic exp_oe();
    return m_qv && !oe_n && !sleep && (m_wake == 0);
  endfunction

  task automatic model_edge();
    logic proc, ctl, ok, doacc;
    logic [NL-1:0] msk;
    logic [AW-1:0] ea;
    m_err = 1'b0;
    ea = '0;
    if (sleep) m_wake = 2;
    else if (m_wake > 0) begin
      m_err = !strb_proc_n || !strb_ctl_n;
      m_wake--;
    end else begin
      msk   = !gwr_n ? '1 : (!bwr_n ? ~lane_wr_n : '0);
      proc  = !strb_proc_n && !sel_a_n;
      ctl   = !strb_ctl_n && !proc;
      doacc = 1'b0;
      if (proc || ctl) begin
        ok = !sel_a_n && sel_b && !sel_c_n;
        m_act = ok;
        if (ok) begin
          m_base = addr; m_step = 2'd0; ea = addr; doacc = 1'b1;
          if (proc) msk = '0;
        end
      end else if (m_act) begin
        if (!adv_n) m_step = m_step + 2'd1;
        ea = {m_base[AW-1:2], seq_ilv ? (m_base[1:0] ^ m_step) : (m_base[1:0] + m_step)};
        doacc = 1'b1;
      end
      if (doacc && msk != '0) begin
        for (int l = 0; l < NL; l++)
          if (msk[l]) ref_mem[ea][l*LW +: LW] = wdata[l*LW +: LW];
        m_qv = 1'b0;
      end else if (doacc) begin
        m_q  = ref_mem[ea];
        m_qv = 1'b1;
      end else begin
        m_qv = 1'b0;
      end
    end
  endtask

  task automatic step(input logic [22:0] v);
    @(negedge clk);
    strb_proc_n = v[18]; strb_ctl_n = v[17]; adv_n = v[16];
    sel_a_n = v[15]; sel_b = v[14]; sel_c_n = v[13];
    gwr_n = v[12]; bwr_n = v[11]; lane_wr_n = v[10:7];
    seq_ilv = v[6]; addr = v[5:0];
    wdata = 36'h5A3C96E1F ^ (36'(n_step) * 36'h01F3D5B79);
    n_step++;
    @(posedge clk);
    model_edge();
    #1;
    chk(int'(v[22:19]), rdata, exp_oe() ? m_q : '0);
    chk(int'(v[22:19]), WW'(dq_oe), WW'(exp_oe()));
    chk(13, WW'(wake_err), WW'(m_err)); // R13
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(1, WW'(dq_oe), '0);
    chk(1, rdata, '0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(1, WW'(dq_oe), '0);
    chk(1, WW'(wake_err), '0);

    for (int i = 0; i < NV; i++) step(VEC[i]);

    // R12: sleep keeps contents and state, R13 wake window
    step({4'd2, 3'b011, 3'b010, 2'b11, 4'hF, 1'b0, 6'd9});
    sleep = 1'b1;
    #1;
    chk(12, WW'(dq_oe), '0);
    chk(12, rdata, '0);
    step({4'd12, 3'b101, 3'b010, 2'b01, 4'hF, 1'b0, 6'd9}); // write attempt asleep
    step({4'd12, 3'b111, 3'b010, 2'b11, 4'hF, 1'b0, 6'd0});
    sleep = 1'b0;
    step({4'd13, 3'b101, 3'b010, 2'b11, 4'hF, 1'b0, 6'd9}); // strobe in window
    chk(13, WW'(wake_err), WW'(1'b1));
    step({4'd12, 3'b111, 3'b010, 2'b11, 4'hF, 1'b0, 6'd0});
    step({4'd12, 3'b011, 3'b010, 2'b11, 4'hF, 1'b0, 6'd9}); // data preserved
    chk(12, WW'(dq_oe), WW'(1'b1));

    // R11: output enable acts between edges
    oe_n = 1'b1;
    #1;
    chk(11, WW'(dq_oe), '0);
    chk(11, rdata, '0);
    oe_n = 1'b0;
    #1;
    chk(11, WW'(dq_oe), WW'(exp_oe()));
    chk(11, rdata, m_q);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule